// File: doc/BRIEF.md
# SPI Configuration Programming Sequencer

This block sits on the controller side of an SPI link and loads a configuration image into a target device without help from software. A host gives it a start pulse, the image length in bytes and a flag that asks for partial reconfiguration. The block then runs a fixed order of steps:

- It turns on configuration access and reads a four-byte reply that must be zero.
- It puts the target into program mode.
- It streams the image in 16-byte frames taken from a first-word-fall-through byte FIFO.
- It turns configuration access off, waits a set time, and releases the target.

Before every command the block polls the target's status. It sends a status request through a request/acknowledge handshake and goes on only when the reply meets the step's condition.

The block does not shift bits itself. It hands bytes to an SPI byte engine over a valid/ready handshake, and it marks the last byte of each chip-select window. The byte received during each accepted byte comes back the same cycle.

At the end of a session the block pulses `done`. `err_code` then holds the outcome until the next session starts, and `prog_mode` shows whether the target was left in program mode.

Top module: `cfgload_seq`

## Requirements
- R1: After reset `busy`, `done`, `prog_mode`, `spi_valid`, `poll_req` and `fifo_rd` are 0, and `err_code` is 0 (no error).
- R2: A start with `partial_req` high ends the session with `err_code` = 1 and a `done` pulse. No status poll, SPI byte or FIFO read is issued.
- R3: A start with an image length that is not a multiple of 16 ends with `err_code` = 2 and a `done` pulse. No traffic of any kind is issued.
- R4: The session opens with status polling until bit 0 (busy) reads 0. Then byte 0x0B is sent alone, with `spi_last` set on it.
- R5: Next the block polls until bit 0 is 0 and bit 1 (ready) is 1. It then sends 0x01 followed by four 0x00 bytes in one window. If any of the four received bytes is nonzero, the session ends with `err_code` = 3 and no further traffic.
- R6: After a poll with busy clear, 0xAE then 0x01 go out in one window. `prog_mode` rises after that window.
- R7: Each frame follows its own busy-clear poll and is 0xEE plus the next 16 FIFO bytes in order, in one window. `fifo_rd` pulses once per data byte. When the FIFO is empty, sending stalls without emitting a byte.
- R8: After the last frame 0x0C is sent. The poll before release starts WAIT cycles after the 0x0C byte is accepted. WAIT is the parameterized clock rate times the microsecond delay, or the test override. Then 0x23 is sent, `prog_mode` falls, and the session ends with `err_code` = 0.
- R9: A status reply with bit 2 or bit 3 set ends the session at once with `err_code` = 4.
- R10: If POLL_LIMIT status replies in one poll all fail the condition, the session ends with `err_code` = 5. No byte of that step is sent.
- R11: While `spi_valid` is high and `spi_ready` is low, the byte and `spi_last` stay unchanged.
- R12: `done` lasts one cycle. `err_code` holds its value until the next start. `busy` is high while a session runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Session start pulse (ignored while busy) |
| partial_req | input | 1 | Partial reconfiguration asked for (refused) |
| img_bytes | input | LEN_W | Image length in bytes |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| err_code | output | 3 | Outcome code of the last session |
| prog_mode | output | 1 | Target is in program mode |
| poll_req | output | 1 | Status read request |
| poll_ack | input | 1 | Status read completed |
| poll_status | input | 8 | Status byte, valid with poll_ack |
| spi_valid | output | 1 | Byte offered to the SPI byte engine |
| spi_ready | input | 1 | Byte engine accepts the byte |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Chip select ends after this byte |
| spi_rx | input | 8 | Byte received during the accepted byte |
| fifo_rd | output | 1 | Pop the image FIFO |
| fifo_data | input | 8 | FIFO head byte |
| fifo_empty | input | 1 | FIFO has no byte |

## Verification
A wrong step or byte index shows up as a wrong byte in the SPI stream, or a wrong `spi_last` boundary. The window where it happens is the window that is already open. The bench therefore records every accepted byte with its window marker and compares the whole record against a stream built from the requirements.

A bad poll or reply decision shows up at `err_code` and in traffic that is missing or extra. A frame counter that is off changes the number of 0xEE windows and the FIFO read count by the next frame. A wrong wait counter moves the release poll away from the expected cycle by that many cycles.

// File: rtl/cfgload_pkg.sv
`timescale 1ns/1ps
package cfgload_pkg;

  localparam int unsigned FRAME_LOG2  = 4;
  localparam int unsigned FRAME_BYTES = 1 << FRAME_LOG2;
  localparam int unsigned REPLY_BYTES = 4;

  // command bytes; their order in a session is behaviour
  localparam logic [7:0] OP_CFG_ON   = 8'h0B;
  localparam logic [7:0] OP_FETCH    = 8'h01;
  localparam logic [7:0] OP_FILL     = 8'h00;
  localparam logic [7:0] OP_MODE_PFX = 8'hAE;
  localparam logic [7:0] OP_MODE_ARG = 8'h01;
  localparam logic [7:0] OP_FRAME    = 8'hEE;
  localparam logic [7:0] OP_CFG_OFF  = 8'h0C;
  localparam logic [7:0] OP_RELEASE  = 8'h23;

  // status byte bit positions
  localparam int unsigned SB_BUSY  = 0;
  localparam int unsigned SB_READY = 1;
  localparam int unsigned SB_VIOL  = 2;
  localparam int unsigned SB_FAULT = 3;

  typedef enum logic [2:0] {
    ST_ENABLE, ST_QUERY, ST_PROGRAM, ST_FRAME, ST_DISABLE, ST_RELEASE
  } step_e;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_PARTIAL = 3'd1,
    E_LENGTH  = 3'd2,
    E_REPLY   = 3'd3,
    E_STATUS  = 3'd4,
    E_TIMEOUT = 3'd5
  } err_e;

  // bytes in the chip-select window of a step
  function automatic logic [4:0] step_len(input step_e s);
    case (s)
      ST_QUERY:   return 5'(1 + REPLY_BYTES);
      ST_PROGRAM: return 5'd2;
      ST_FRAME:   return 5'(1 + FRAME_BYTES);
      default:    return 5'd1;
    endcase
  endfunction

  // fixed byte of a step at a window position
  function automatic logic [7:0] step_byte(input step_e s, input logic [4:0] idx);
    case (s)
      ST_ENABLE:  return OP_CFG_ON;
      ST_QUERY:   return (idx == 5'd0) ? OP_FETCH : OP_FILL;
      ST_PROGRAM: return (idx == 5'd0) ? OP_MODE_PFX : OP_MODE_ARG;
      ST_FRAME:   return OP_FRAME;
      ST_DISABLE: return OP_CFG_OFF;
      default:    return OP_RELEASE;
    endcase
  endfunction

  // true when the byte at idx comes from the image FIFO
  function automatic logic step_streams(input step_e s, input logic [4:0] idx);
    return (s == ST_FRAME) && (idx != 5'd0);
  endfunction

  // status bits that must be set, besides busy being clear
  function automatic logic [7:0] poll_mask(input step_e s);
    return (s == ST_QUERY) ? (8'(1) << SB_READY) : 8'h00;
  endfunction

  function automatic logic poll_met(input logic [7:0] st, input logic [7:0] mask);
    return (st & (mask | (8'(1) << SB_BUSY))) == mask;
  endfunction

  function automatic logic poll_bad(input logic [7:0] st);
    return st[SB_VIOL] | st[SB_FAULT];
  endfunction

  function automatic logic len_aligned(input logic [31:0] n);
    return n[FRAME_LOG2-1:0] == '0;
  endfunction

endpackage

// File: rtl/cfgload_poll.sv
`timescale 1ns/1ps
module cfgload_poll
  import cfgload_pkg::*;
#(
  parameter int unsigned LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] mask,
  output logic       poll_req,
  input  logic       poll_ack,
  input  logic [7:0] poll_status,
  output logic       ok,
  output logic       fail,
  output err_e       fail_code
);

  localparam int unsigned TW = $clog2(LIMIT + 1);

  logic [TW-1:0] tries;
  logic          reply_seen;
  logic          is_bad;
  logic          is_met;
  logic          last_try;

  assign poll_req   = en;
  assign reply_seen = en && poll_ack;
  assign is_bad     = poll_bad(poll_status);
  assign is_met     = poll_met(poll_status, mask);
  assign last_try   = (tries == TW'(LIMIT - 1));

  assign ok        = reply_seen && !is_bad && is_met;
  assign fail      = reply_seen && (is_bad || (!is_met && last_try));
  assign fail_code = is_bad ? E_STATUS : E_TIMEOUT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries <= '0;
    end else if (!en) begin
      tries <= '0;
    end else if (reply_seen && !ok && !fail) begin
      tries <= tries + 1'b1;
    end
  end

  // R10: the retry count never passes the budget
  p_tries_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(LIMIT));

  // R9: a flagged reply never counts as success
  p_bad_not_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_seen && (poll_status[SB_VIOL] || poll_status[SB_FAULT])) |-> !ok);

endmodule

// File: rtl/cfgload_timer.sv
`timescale 1ns/1ps
module cfgload_timer #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= CW'(CYCLES - 1);
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expired = running && (cnt == '0);

  // R8: no reload while a wait is in progress
  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !running);

endmodule

// File: rtl/cfgload_reply.sv
`timescale 1ns/1ps
module cfgload_reply
  import cfgload_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cap,
  input  logic [7:0] rx,
  output logic       nonzero
);

  localparam int unsigned SW = $clog2(REPLY_BYTES + 1);

  logic          acc;
  logic [SW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= 1'b0;
      seen <= '0;
    end else if (clr) begin
      acc  <= 1'b0;
      seen <= '0;
    end else if (cap) begin
      acc  <= acc | (rx != 8'h00);
      seen <= seen + 1'b1;
    end
  end

  assign nonzero = acc | (cap && (rx != 8'h00));

  // R5: no more reply bytes are taken than the reply holds
  p_reply_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= SW'(REPLY_BYTES));

endmodule

// File: rtl/cfgload_seq.sv
`timescale 1ns/1ps
module cfgload_seq
  import cfgload_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned WAIT_US       = 1500,
  parameter int unsigned WAIT_OVERRIDE = 0,
  parameter int unsigned POLL_LIMIT    = 200_000,
  parameter int unsigned LEN_W         = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             partial_req,
  input  logic [LEN_W-1:0] img_bytes,
  output logic             busy,
  output logic             done,
  output logic [2:0]       err_code,
  output logic             prog_mode,
  output logic             poll_req,
  input  logic             poll_ack,
  input  logic [7:0]       poll_status,
  output logic             spi_valid,
  input  logic             spi_ready,
  output logic [7:0]       spi_tx,
  output logic             spi_last,
  input  logic [7:0]       spi_rx,
  output logic             fifo_rd,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_empty
);

  localparam int unsigned WAIT_CYC = (WAIT_OVERRIDE != 0) ? WAIT_OVERRIDE
                                   : (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int unsigned FRM_W    = LEN_W - FRAME_LOG2;
  localparam int unsigned WCW      = $clog2(WAIT_CYC + 1);

  typedef enum logic [1:0] {M_IDLE, M_POLL, M_XFER, M_WAIT} mode_e;

  mode_e            state_q;
  step_e            step_q;
  logic [4:0]       idx_q;
  logic [FRM_W-1:0] frames_q;
  err_e             err_q;
  logic             done_q;
  logic             prog_q;

  // named internal events
  logic       beat;
  logic       win_end;
  logic       from_fifo;
  logic [4:0] last_idx;
  logic       poll_ok;
  logic       poll_fail;
  err_e       poll_code;
  logic       reply_nz;
  logic       reply_cap;
  logic       wait_load;
  logic       wait_over;

  assign last_idx  = step_len(step_q) - 5'd1;
  assign from_fifo = step_streams(step_q, idx_q);
  assign spi_valid = (state_q == M_XFER) && !(from_fifo && fifo_empty);
  assign spi_tx    = from_fifo ? fifo_data : step_byte(step_q, idx_q);
  assign spi_last  = (idx_q == last_idx);
  assign beat      = spi_valid && spi_ready;
  assign win_end   = beat && spi_last;
  assign fifo_rd   = beat && from_fifo;
  assign reply_cap = beat && (step_q == ST_QUERY) && (idx_q != 5'd0);
  assign wait_load = win_end && (step_q == ST_DISABLE);

  cfgload_poll #(.LIMIT(POLL_LIMIT)) poll_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (state_q == M_POLL),
    .mask        (poll_mask(step_q)),
    .poll_req    (poll_req),
    .poll_ack    (poll_ack),
    .poll_status (poll_status),
    .ok          (poll_ok),
    .fail        (poll_fail),
    .fail_code   (poll_code)
  );

  cfgload_reply reply_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state_q == M_IDLE),
    .cap     (reply_cap),
    .rx      (spi_rx),
    .nonzero (reply_nz)
  );

  cfgload_timer #(.CYCLES(WAIT_CYC)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wait_load),
    .expired (wait_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= M_IDLE;
      step_q   <= ST_ENABLE;
      idx_q    <= '0;
      frames_q <= '0;
      err_q    <= E_NONE;
      done_q   <= 1'b0;
      prog_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        M_IDLE: begin
          if (start) begin
            if (partial_req) begin
              err_q  <= E_PARTIAL;
              done_q <= 1'b1;
            end else if (!len_aligned(32'(img_bytes))) begin
              err_q  <= E_LENGTH;
              done_q <= 1'b1;
            end else begin
              err_q    <= E_NONE;
              state_q  <= M_POLL;
              step_q   <= ST_ENABLE;
              idx_q    <= '0;
              frames_q <= img_bytes[LEN_W-1:FRAME_LOG2];
            end
          end
        end
        M_POLL: begin
          if (poll_fail) begin
            err_q   <= poll_code;
            done_q  <= 1'b1;
            state_q <= M_IDLE;
          end else if (poll_ok) begin
            state_q <= M_XFER;
            idx_q   <= '0;
          end
        end
        M_XFER: begin
          if (beat && !spi_last) begin
            idx_q <= idx_q + 5'd1;
          end else if (win_end) begin
            state_q <= M_POLL;
            case (step_q)
              ST_ENABLE: step_q <= ST_QUERY;
              ST_QUERY: begin
                if (reply_nz) begin
                  err_q   <= E_REPLY;
                  done_q  <= 1'b1;
                  state_q <= M_IDLE;
                end else begin
                  step_q <= ST_PROGRAM;
                end
              end
              ST_PROGRAM: begin
                prog_q <= 1'b1;
                step_q <= (frames_q == '0) ? ST_DISABLE : ST_FRAME;
              end
              ST_FRAME: begin
                frames_q <= frames_q - 1'b1;
                if (frames_q == FRM_W'(1)) step_q <= ST_DISABLE;
              end
              ST_DISABLE: state_q <= M_WAIT;
              default: begin
                prog_q  <= 1'b0;
                done_q  <= 1'b1;
                state_q <= M_IDLE;
              end
            endcase
          end
        end
        default: begin
          if (wait_over) begin
            step_q  <= ST_RELEASE;
            state_q <= M_POLL;
          end
        end
      endcase
    end
  end

  assign busy      = (state_q != M_IDLE);
  assign done      = done_q;
  assign err_code  = err_q;
  assign prog_mode = prog_q;

  // cycles spent in the wait, for the span check
  logic [WCW-1:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                wait_cnt <= '0;
    else if (state_q != M_WAIT) wait_cnt <= '0;
    else                       wait_cnt <= wait_cnt + 1'b1;
  end

  // R4: every window opens right after a successful poll
  p_window_after_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_XFER && $past(state_q) != M_XFER) |-> $past(poll_ok));

  // R11: offered byte is held until taken
  p_byte_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid && !spi_ready) |=> (spi_valid && $stable(spi_tx) && $stable(spi_last)));

  // R7: frames are only streamed in program mode
  p_frame_in_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid && step_q == ST_FRAME) |-> prog_mode);

  // R8: the wait lasts exactly WAIT_CYC cycles
  p_wait_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_POLL && $past(state_q) == M_WAIT) |-> ($past(wait_cnt) == WCW'(WAIT_CYC - 1)));

  // R8: program mode drops only at release
  p_prog_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_mode) |-> ($past(step_q) == ST_RELEASE));

  // R2: no traffic while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_IDLE) |-> (!spi_valid && !poll_req && !fifo_rd));

  // R9: status request stays up until answered
  p_req_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !poll_ack) |=> poll_req);

  // R12: done is a single-cycle pulse
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/cfgload_seq_tb_top.sv
`timescale 1ns/1ps
module cfgload_seq_tb_top;

  localparam int LEN_W = 16;
  localparam int WAITC = 20;
  localparam int PLIM  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             partial_req = 1'b0;
  logic [LEN_W-1:0] img_bytes = '0;
  logic             busy, done, prog_mode, poll_req, spi_valid, spi_last, fifo_rd;
  logic [2:0]       err_code;
  logic [7:0]       spi_tx;
  logic             poll_ack;
  logic [7:0]       poll_status;
  logic             spi_ready;
  logic [7:0]       spi_rx;
  logic [7:0]       fifo_data;
  logic             fifo_empty;

  always #5 clk = ~clk;

  cfgload_seq #(
    .WAIT_OVERRIDE (WAITC),
    .POLL_LIMIT    (PLIM),
    .LEN_W         (LEN_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
    .img_bytes(img_bytes), .busy(busy), .done(done), .err_code(err_code),
    .prog_mode(prog_mode), .poll_req(poll_req), .poll_ack(poll_ack),
    .poll_status(poll_status), .spi_valid(spi_valid), .spi_ready(spi_ready),
    .spi_tx(spi_tx), .spi_last(spi_last), .spi_rx(spi_rx), .fifo_rd(fifo_rd),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty)
  );

  // ---------------- bench models ----------------
  int          cyc = 0;
  logic [31:0] reply_w = '0;
  int          busy_n = 0;
  logic        fault_mode = 1'b0;
  int          avail = 0;

  always @(posedge clk) cyc <= cyc + 1;
  assign spi_ready = (cyc % 3) != 2;

  function automatic logic [7:0] img_byte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  logic [7:0] log_b [256];
  logic       log_l [256];
  int         log_n, pos, rd_ptr, ack_n, hold_err, fifo_err, done_cnt;
  int         t_dis, t_rel;
  logic       dis_seen, prev_req, prev_stall;
  logic [7:0] prev_tx;
  int         seq_n;

  assign fifo_data  = img_byte(rd_ptr);
  assign fifo_empty = (rd_ptr >= avail);

  always_comb begin
    case (pos)
      1: spi_rx = reply_w[7:0];
      2: spi_rx = reply_w[15:8];
      3: spi_rx = reply_w[23:16];
      4: spi_rx = reply_w[31:24];
      default: spi_rx = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      log_n <= 0; pos <= 0; rd_ptr <= 0; ack_n <= 0; hold_err <= 0; fifo_err <= 0;
      done_cnt <= 0; dis_seen <= 1'b0; prev_req <= 1'b0; prev_stall <= 1'b0;
      prev_tx <= 8'h00; seq_n <= 0; poll_ack <= 1'b0; poll_status <= 8'h00;
      t_dis <= 0; t_rel <= 0;
    end else begin
      if (spi_valid && spi_ready) begin
        log_b[log_n] <= spi_tx;
        log_l[log_n] <= spi_last;
        log_n <= log_n + 1;
        pos <= spi_last ? 0 : pos + 1;
        if (spi_tx == 8'h0C && spi_last) begin
          dis_seen <= 1'b1;
          t_dis    <= cyc;
        end
      end
      if (prev_stall && !(spi_valid && spi_tx == prev_tx)) hold_err <= hold_err + 1;
      prev_stall <= spi_valid && !spi_ready;
      prev_tx    <= spi_tx;
      if (fifo_rd) begin
        if (fifo_empty) fifo_err <= fifo_err + 1;
        rd_ptr <= rd_ptr + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
      if (poll_req && !prev_req && dis_seen) begin
        t_rel    <= cyc;
        dis_seen <= 1'b0;
      end
      prev_req <= poll_req;
      if (poll_req && !poll_ack) begin
        poll_ack    <= 1'b1;
        poll_status <= fault_mode ? 8'h08 : ((seq_n < busy_n) ? 8'h01 : 8'h02);
        seq_n       <= seq_n + 1;
        ack_n       <= ack_n + 1;
      end else begin
        poll_ack <= 1'b0;
      end
      if (!poll_req) seq_n <= 0;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [7:0] exp_b [256];
  logic       exp_l [256];
  int         exp_n;

  task automatic push(input logic [7:0] b, input logic l);
    exp_b[exp_n] = b;
    exp_l[exp_n] = l;
    exp_n++;
  endtask

  task automatic build_exp(input bit partial, input int nb, input logic [31:0] rep);
    exp_n = 0;
    if (partial || (nb % 16) != 0) return;
    push(8'h0B, 1'b1);
    push(8'h01, 1'b0);
    for (int k = 0; k < 4; k++) push(8'h00, k == 3);
    if (rep != 0) return;
    push(8'hAE, 1'b0);
    push(8'h01, 1'b1);
    for (int f = 0; f < nb / 16; f++) begin
      push(8'hEE, 1'b0);
      for (int k = 0; k < 16; k++) push(img_byte(f * 16 + k), k == 15);
    end
    push(8'h0C, 1'b1);
    push(8'h23, 1'b1);
  endtask

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < exp_n; i++)
      if (log_b[i] !== exp_b[i] || log_l[i] !== exp_l[i]) m++;
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start(input bit partial, input int nb);
    partial_req = partial;
    img_bytes   = LEN_W'(nb);
    start       = 1'b1;
    @(negedge clk);
    start       = 1'b0;
  endtask

  task automatic wait_done(output logic [2:0] e, output bit got);
    got = 1'b0;
    e   = 3'd7;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin
        got = 1'b1;
        e   = err_code;
        return;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        partial;
    logic [15:0] nbytes;
    logic [7:0]  busy_polls;
    logic [31:0] reply;
    logic [2:0]  err;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{1'b0, 16'd32, 8'd0, 32'h0000_0000, 3'd0},
    '{1'b0, 16'd48, 8'd3, 32'h0000_0000, 3'd0},
    '{1'b0, 16'd0,  8'd1, 32'h0000_0000, 3'd0},
    '{1'b1, 16'd32, 8'd0, 32'h0000_0000, 3'd1},
    '{1'b0, 16'd40, 8'd0, 32'h0000_0000, 3'd2},
    '{1'b0, 16'd16, 8'd2, 32'h0001_0000, 3'd3},
    '{1'b0, 16'd64, 8'd2, 32'h0000_0000, 3'd0}
  };

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 200000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [2:0] e;
    bit         got;

    // R1: reset state
    do_reset();
    chk(!busy && !done && !prog_mode, "R1", "busy/done/prog after reset",
        int'({busy, done, prog_mode}), 0);
    chk(err_code == 3'd0, "R1", "err_code after reset", int'(err_code), 0);
    chk(!spi_valid && !poll_req && !fifo_rd, "R1", "traffic after reset",
        int'({spi_valid, poll_req, fifo_rd}), 0);

    // table of sessions: R2 R3 R4 R5 R6 R7 R8 R11 R12
    for (int v = 0; v < 7; v++) begin
      do_reset();
      busy_n     = int'(VT[v].busy_polls);
      reply_w    = VT[v].reply;
      fault_mode = 1'b0;
      avail      = int'(VT[v].nbytes);
      build_exp(VT[v].partial, int'(VT[v].nbytes), VT[v].reply);
      pulse_start(VT[v].partial, int'(VT[v].nbytes));
      wait_done(e, got);
      chk(got, "R12", "done seen", int'(got), 1);
      chk(e == VT[v].err, "R2 R3 R5 R8", "err_code", int'(e), int'(VT[v].err));
      repeat (6) @(negedge clk);
      chk(log_n == exp_n, "R4 R5 R6 R7 R8", "byte count", log_n, exp_n);
      chk(mismatches() == 0, "R4 R5 R6 R7 R8", "stream bytes/window marks",
          mismatches(), 0);
      chk(rd_ptr == ((VT[v].err == 3'd0) ? int'(VT[v].nbytes) : 0), "R7",
          "fifo reads", rd_ptr, (VT[v].err == 3'd0) ? int'(VT[v].nbytes) : 0);
      chk(!prog_mode, "R8", "prog_mode at end", int'(prog_mode), 0);
      chk(hold_err == 0 && fifo_err == 0, "R11", "byte hold / empty reads",
          hold_err + fifo_err, 0);
      chk(done_cnt == 1, "R12", "done pulse cycles", done_cnt, 1);
      chk(err_code == VT[v].err && !busy, "R12", "err held after done",
          int'(err_code), int'(VT[v].err));
      if (VT[v].err == 3'd0)
        chk((t_rel - t_dis) >= WAITC && (t_rel - t_dis) <= WAITC + 2, "R8",
            "disable to release-poll cycles", t_rel - t_dis, WAITC + 1);
      if (VT[v].partial || VT[v].err == 3'd2)
        chk(ack_n == 0, "R2 R3", "status polls issued", ack_n, 0);
    end

    // R9: flagged status reply
    do_reset();
    busy_n = 0; reply_w = '0; fault_mode = 1'b1; avail = 32;
    pulse_start(1'b0, 32);
    wait_done(e, got);
    chk(e == 3'd4, "R9", "err_code on flagged status", int'(e), 4);
    repeat (4) @(negedge clk);
    chk(log_n == 0, "R9", "bytes sent after flagged status", log_n, 0);
    fault_mode = 1'b0;

    // R10: poll budget runs out
    do_reset();
    busy_n = 100; avail = 32;
    pulse_start(1'b0, 32);
    wait_done(e, got);
    chk(e == 3'd5, "R10", "err_code on poll timeout", int'(e), 5);
    repeat (4) @(negedge clk);
    chk(log_n == 0, "R10", "bytes sent after timeout", log_n, 0);
    chk(ack_n == PLIM, "R10", "status replies consumed", ack_n, PLIM);

    // R7: empty FIFO stalls the second frame, R6: prog_mode up mid session
    do_reset();
    busy_n = 1; avail = 20;
    build_exp(1'b0, 32, 32'h0);
    pulse_start(1'b0, 32);
    repeat (300) @(negedge clk);
    chk(log_n == 30, "R7", "bytes sent while FIFO empty", log_n, 30);
    chk(rd_ptr == 20, "R7", "fifo reads while stalled", rd_ptr, 20);
    chk(prog_mode && busy, "R6", "prog_mode/busy during frames",
        int'({prog_mode, busy}), 3);
    avail = 32;
    wait_done(e, got);
    chk(e == 3'd0, "R7", "err_code after stall", int'(e), 0);
    repeat (4) @(negedge clk);
    chk(log_n == exp_n && mismatches() == 0, "R7", "stream after stall",
        mismatches(), 0);

    // R12: start while busy is ignored
    do_reset();
    busy_n = 0; avail = 16;
    build_exp(1'b0, 16, 32'h0);
    pulse_start(1'b0, 16);
    repeat (5) @(negedge clk);
    pulse_start(1'b1, 16);
    wait_done(e, got);
    chk(e == 3'd0, "R12", "err_code with start while busy", int'(e), 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1 && mismatches() == 0, "R12", "single session stream",
        done_cnt, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule